// File: doc/BRIEF.md
# Floating-Point Exception Mode Resolution Stage

This stage sits directly behind a binary64 arithmetic unit and decides what happens to each result once the unit has classified it. The unit supplies five raised-exception flags, the result it would deliver under IEEE default handling, and the result sign. A 10-bit control word gives every exception its own 2-bit handling mode. From these the stage picks the final result, decides whether the destination register is written, and raises a trap request. It registers everything for one cycle, so the five current-exception bits leave the stage in step with the result they describe.

The modes are IEEE default, trap, flush/saturate and a fourth mode whose meaning depends on the exception. Flush/saturate turns tiny results into a signed zero. It turns overflowed or divide-by-zero infinities into the signed largest finite magnitude. For overflow and underflow the fourth mode means exponent wrap, which is done upstream, so the stage passes the result through. For divide-by-zero and invalid it means inhibited: the exception is recorded but the destination keeps its old value. A held inhibited flag lets a following conditional branch test whether the last operation took that path.

Top module: `fp_exc_resolve`

## Requirements
- R1: While rst_ni is low, valid_o, wr_en_o, trap_o and inhibited_o are 0, and res_o and cexc_o are all zeros.
- R2: Outputs appear one clock after an operation is presented with valid_i=1. When valid_i=0, valid_o, wr_en_o and trap_o are 0 one clock later. wr_en_o is never 1 without valid_o.
- R3: cexc_o repeats the raised flags of the operation in the same cycle as its result, whatever the modes. Bit order in exc_i and cexc_o: [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow, [4] inexact. The mode for exception bit k sits in mode_i[2k+1:2k]. Mode codes: 0 default, 1 trap, 2 flush/saturate, 3 wrap/inhibited.
- R4: When no raised exception selects a non-default action, res_o equals res_i and wr_en_o is 1.
- R5: Any raised exception whose mode is 1, inexact included, sets trap_o, clears wr_en_o and passes res_i through.
- R6: Overflow raised with mode 2 gives res_o = {sign_i, 63'h7FEFFFFFFFFFFFFF} and a write.
- R7: Underflow raised with mode 2 gives res_o = {sign_i, 63'h0} and a write.
- R8: Divide-by-zero raised with mode 2 gives res_o = {sign_i, 63'h7FEFFFFFFFFFFFFF} and a write.
- R9: Mode 2 on invalid, and mode 2 or 3 on inexact, act as default handling.
- R10: Mode 3 on overflow or underflow passes res_i through with a write and does not set inhibited_o.
- R11: Divide-by-zero or invalid raised with mode 3 clears wr_en_o and sets inhibited_o, and the cexc_o bit is still set.
- R12: inhibited_o keeps its value while valid_i is 0. It is reloaded by every accepted operation.
- R13: Trap wins over inhibited, and inhibited wins over substitution. When both trap and inhibited apply, inhibited_o is 0. Modes of exceptions that are not raised have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation outcome is presented |
| exc_i | input | 5 | Raised exception flags from the arithmetic unit |
| mode_i | input | 10 | Per-exception 2-bit handling modes |
| res_i | input | 64 | IEEE default result |
| sign_i | input | 1 | Sign of the exact result |
| valid_o | output | 1 | Registered operation valid |
| res_o | output | 64 | Final result |
| wr_en_o | output | 1 | Destination register write enable |
| trap_o | output | 1 | Trap request |
| cexc_o | output | 5 | Current-exception bits of this result |
| inhibited_o | output | 1 | Last operation was inhibited (held) |

## Verification
The bench targets the places where modes overlap. In one case divide-by-zero is inhibited while overflow is set to saturate. A design with the wrong priority would write a saturated value into a register that should stay untouched. In another, trap and inhibited hit at the same time, and a broken design would report both. Mode 3 on overflow must not be read as inhibited, or the write would be lost. Mode 2 on invalid or inexact must not substitute, or a NaN would be rewritten as a finite value. The sign of flushed zeros is checked both ways. The bench also checks that the inhibited flag survives idle cycles, because a design that cleared it on every clock would leave the branch unit with nothing to test.

// File: rtl/fp_exc_pkg.sv
package fp_exc_pkg;
  localparam int NUM_EXC = 5;
  localparam int DATA_W  = 64;
  localparam int MODE_W  = 2;

  localparam int EXC_INV = 0;
  localparam int EXC_DZ  = 1;
  localparam int EXC_OF  = 2;
  localparam int EXC_UF  = 3;
  localparam int EXC_NX  = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_IEEE  = 2'd0,
    MODE_TRAP  = 2'd1,
    MODE_FLUSH = 2'd2,
    MODE_ALT   = 2'd3
  } exc_mode_e;

  localparam logic [DATA_W-2:0] MAX_MAG = 63'h7FEF_FFFF_FFFF_FFFF;
endpackage

// File: rtl/fp_exc_decode.sv
module fp_exc_decode
  import fp_exc_pkg::*;
#(
  parameter int N_EXC = NUM_EXC
) (
  input  logic [N_EXC-1:0]        exc_i,
  input  logic [MODE_W*N_EXC-1:0] mode_i,
  output logic [N_EXC-1:0]        trap_hit_o,
  output logic [N_EXC-1:0]        inh_hit_o,
  output logic [N_EXC-1:0]        flush_hit_o
);
  for (genvar k = 0; k < N_EXC; k++) begin : g_exc
    localparam bit CAN_INH   = (k == EXC_INV) || (k == EXC_DZ);
    localparam bit CAN_FLUSH = (k == EXC_OF) || (k == EXC_UF) || (k == EXC_DZ);
    exc_mode_e mode;
    assign mode           = exc_mode_e'(mode_i[MODE_W*k +: MODE_W]);
    assign trap_hit_o[k]  = exc_i[k] && (mode == MODE_TRAP);
    assign inh_hit_o[k]   = CAN_INH && exc_i[k] && (mode == MODE_ALT);
    assign flush_hit_o[k] = CAN_FLUSH && exc_i[k] && (mode == MODE_FLUSH);
  end
endmodule

// File: rtl/fp_exc_subst.sv
module fp_exc_subst
  import fp_exc_pkg::*;
(
  input  logic [DATA_W-1:0]  res_i,
  input  logic               sign_i,
  input  logic [NUM_EXC-1:0] flush_hit_i,
  output logic [DATA_W-1:0]  res_o
);
  always_comb begin
    if (flush_hit_i[EXC_OF] || flush_hit_i[EXC_DZ])
      res_o = {sign_i, MAX_MAG};
    else if (flush_hit_i[EXC_UF])
      res_o = {sign_i, {(DATA_W-1){1'b0}}};
    else
      res_o = res_i;
  end
endmodule

// File: rtl/fp_exc_resolve.sv
module fp_exc_resolve
  import fp_exc_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [NUM_EXC-1:0]        exc_i,
  input  logic [MODE_W*NUM_EXC-1:0] mode_i,
  input  logic [DATA_W-1:0]         res_i,
  input  logic                      sign_i,
  output logic                      valid_o,
  output logic [DATA_W-1:0]         res_o,
  output logic                      wr_en_o,
  output logic                      trap_o,
  output logic [NUM_EXC-1:0]        cexc_o,
  output logic                      inhibited_o
);
  logic [NUM_EXC-1:0] trap_hit, inh_hit, flush_hit;
  logic [DATA_W-1:0]  sub_res;
  logic               trap_any, inh_any;

  fp_exc_decode #(.N_EXC(NUM_EXC)) u_decode (
    .exc_i      (exc_i),
    .mode_i     (mode_i),
    .trap_hit_o (trap_hit),
    .inh_hit_o  (inh_hit),
    .flush_hit_o(flush_hit)
  );

  fp_exc_subst u_subst (
    .res_i      (res_i),
    .sign_i     (sign_i),
    .flush_hit_i(flush_hit),
    .res_o      (sub_res)
  );

  // trap > inhibited > substitution
  assign trap_any = |trap_hit;
  assign inh_any  = !trap_any && (|inh_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      res_o       <= '0;
      wr_en_o     <= 1'b0;
      trap_o      <= 1'b0;
      cexc_o      <= '0;
      inhibited_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i && !trap_any && !inh_any;
      trap_o  <= valid_i && trap_any;
      if (valid_i) begin
        res_o       <= (trap_any || inh_any) ? res_i : sub_res;
        cexc_o      <= exc_i;
        inhibited_o <= inh_any;
      end
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !wr_en_o && !trap_o));
  assert_wr_needs_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);
  assert_cexc_track_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (cexc_o == $past(exc_i)));
  assert_trap_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !wr_en_o);
  assert_inh_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && inhibited_o) |-> !wr_en_o);
  assert_inh_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(inhibited_o));
  assert_trap_over_inh_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !inhibited_o);
endmodule

// File: tb/fp_exc_resolve_tb_top.sv
module fp_exc_resolve_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  exc_i = '0;
  logic [9:0]  mode_i = '0;
  logic [63:0] res_i = '0;
  logic        sign_i = 1'b0;
  logic        valid_o, wr_en_o, trap_o, inhibited_o;
  logic [63:0] res_o;
  logic [4:0]  cexc_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fp_exc_resolve dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .exc_i(exc_i),
    .mode_i(mode_i), .res_i(res_i), .sign_i(sign_i), .valid_o(valid_o),
    .res_o(res_o), .wr_en_o(wr_en_o), .trap_o(trap_o), .cexc_o(cexc_o),
    .inhibited_o(inhibited_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [4:0]  exc;
    logic [9:0]  mode;
    logic [63:0] res;
    logic        sgn;
    logic [63:0] eres;
    logic        ewr;
    logic        etrap;
    logic        einh;
  } vec_t;

  localparam logic [63:0] D    = 64'h4000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] PMAX = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NMAX = 64'hFFEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam int NV = 16;

  localparam vec_t VECS [NV] = '{
    '{8'd4,  5'b00000, 10'h000, D,    1'b0, D,    1'b1, 1'b0, 1'b0}, // R4 clean
    '{8'd6,  5'b00100, 10'h020, NINF, 1'b1, NMAX, 1'b1, 1'b0, 1'b0}, // R6 neg saturate
    '{8'd7,  5'b11000, 10'h080, 64'h123, 1'b0, 64'h0, 1'b1, 1'b0, 1'b0}, // R7 +0
    '{8'd7,  5'b11000, 10'h080, 64'h8000_0000_0000_0123, 1'b1,
             64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0},             // R7 -0
    '{8'd8,  5'b00010, 10'h008, PINF, 1'b0, PMAX, 1'b1, 1'b0, 1'b0}, // R8
    '{8'd9,  5'b00001, 10'h002, QNAN, 1'b0, QNAN, 1'b1, 1'b0, 1'b0}, // R9 invalid flush
    '{8'd5,  5'b00100, 10'h010, PINF, 1'b0, PINF, 1'b0, 1'b1, 1'b0}, // R5 ov trap
    '{8'd5,  5'b10000, 10'h100, D,    1'b0, D,    1'b0, 1'b1, 1'b0}, // R5 inexact trap
    '{8'd9,  5'b10000, 10'h300, D,    1'b0, D,    1'b1, 1'b0, 1'b0}, // R9 inexact mode3
    '{8'd11, 5'b00010, 10'h00C, PINF, 1'b0, PINF, 1'b0, 1'b0, 1'b1}, // R11 dz inhibit
    '{8'd11, 5'b00001, 10'h003, QNAN, 1'b0, QNAN, 1'b0, 1'b0, 1'b1}, // R11 inv inhibit
    '{8'd10, 5'b00100, 10'h030, D,    1'b0, D,    1'b1, 1'b0, 1'b0}, // R10 wrap passes
    '{8'd13, 5'b00011, 10'h00D, QNAN, 1'b0, QNAN, 1'b0, 1'b1, 1'b0}, // R13 trap>inh
    '{8'd13, 5'b00110, 10'h02C, PINF, 1'b0, PINF, 1'b0, 1'b0, 1'b1}, // R13 inh>subst
    '{8'd13, 5'b00000, 10'h3FF, D,    1'b1, D,    1'b1, 1'b0, 1'b0}, // R13 unraised
    '{8'd9,  5'b10100, 10'h2AA, PINF, 1'b0, PMAX, 1'b1, 1'b0, 1'b0}  // R9 inexact mode2
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] e, input logic [9:0] m,
                       input logic [63:0] r, input logic s);
    @(negedge clk_i);
    valid_i = 1'b1; exc_i = e; mode_i = m; res_i = r; sign_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 valid", {63'b0, valid_o}, 64'd0);
    chk("R1 res", res_o, 64'd0);
    chk("R1 flags", {60'b0, wr_en_o, trap_o, inhibited_o, |cexc_o}, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string t;
      drive(VECS[i].exc, VECS[i].mode, VECS[i].res, VECS[i].sgn);
      t = $sformatf("R%0d vec%0d", VECS[i].req, i);
      chk({t, " res"}, res_o, VECS[i].eres);
      chk({t, " wr"}, {63'b0, wr_en_o}, {63'b0, VECS[i].ewr});
      chk({t, " trap"}, {63'b0, trap_o}, {63'b0, VECS[i].etrap});
      chk({t, " inh"}, {63'b0, inhibited_o}, {63'b0, VECS[i].einh});
      chk({t, " R3 cexc"}, {59'b0, cexc_o}, {59'b0, VECS[i].exc});
      chk({t, " R2 valid"}, {63'b0, valid_o}, 64'd1);
    end

    // R12 inhibited held across idle cycles
    drive(5'b00010, 10'h00C, PINF, 1'b0);
    repeat (3) @(negedge clk_i);
    chk("R12 held", {63'b0, inhibited_o}, 64'd1);
    chk("R2 idle valid", {63'b0, valid_o}, 64'd0);
    chk("R2 idle wr", {63'b0, wr_en_o}, 64'd0);
    chk("R2 idle trap", {63'b0, trap_o}, 64'd0);
    drive(5'b00000, 10'h000, D, 1'b0);
    chk("R12 reload", {63'b0, inhibited_o}, 64'd0);

    // R1 reset mid-run after a trap
    drive(5'b00100, 10'h010, PINF, 1'b0);
    chk("R5 pre-reset trap", {63'b0, trap_o}, 64'd1);
    rst_ni = 1'b0;
    #1;
    chk("R1 async trap", {63'b0, trap_o}, 64'd0);
    chk("R1 async res", res_o, 64'd0);
    chk("R1 async cexc", {59'b0, cexc_o}, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule